// File: doc/BRIEF.md
# Register-Register Integer ALU

This block is the execute stage for the base integer register-register operations of a RISC-V style core. Each cycle in which the input strobe is high it takes one 32-bit instruction word and the two source operand values already read from the register file, selects one of ten operations from the instruction's function fields, and one clock later returns an XLEN-bit result with a valid flag and the destination register index. XLEN is a parameter and may be 32 or 64.

The block also splits the instruction word into its three register indices. The two source indices leave combinationally so the surrounding pipeline can address its register file. Every operation passes through the same single register stage. No path depends on operand values, so the cycle count is fixed. An unsupported function-field combination is flagged as illegal and gives a zero result.

Top module: `rr_int_alu`

## Requirements
- R1: With funct3 (instruction bits [14:12]) = 000, funct7 (bits [31:25]) = 0000000 selects ADD and 0100000 selects SUB. Both wrap modulo 2^XLEN and raise no flag.
- R2: funct3 = 100, 110 and 111 with funct7 = 0000000 give the bitwise XOR, OR and AND of the operands.
- R3: funct3 = 010 (funct7 0000000) returns 1 when operand A is less than operand B as two's-complement numbers, otherwise 0. The upper XLEN-1 result bits are zero.
- R4: funct3 = 011 (funct7 0000000) returns 1 when A is less than B as unsigned numbers, otherwise 0. The result is zero-extended.
- R5: Shifts use only the low log2(XLEN) bits of operand B as the amount (5 bits at XLEN 32, 6 bits at XLEN 64). All higher bits of B have no effect on the result.
- R6: funct3 = 001 (funct7 0000000) shifts A left and fills with zeros. funct3 = 101 with funct7 0000000 shifts A right and fills with zeros. funct3 = 101 with funct7 0100000 shifts A right and fills with copies of A's top bit.
- R7: src1_idx equals instruction bits [19:15] and src2_idx equals bits [24:20], combinationally. The registered out_rd equals bits [11:7] of the accepted instruction.
- R8: Every accepted operation (in_valid high at a rising edge) shows its result, out_rd and out_valid high exactly one clock later, whatever the operand values. out_valid is low after a cycle with in_valid low.
- R9: Any funct7 other than 0000000, and other than 0100000 for funct3 000 or 101, sets out_illegal with the result and gives a result of zero.
- R10: A low rst_n at a rising edge (synchronous, active low) clears out_valid, even when in_valid is high.
- R11: While in_valid is low, out_result, out_rd and out_illegal keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept the instruction and operands this cycle |
| instr | input | 32 | Instruction word (register-register format) |
| opnd_a | input | XLEN | First source operand value |
| opnd_b | input | XLEN | Second source operand value |
| src1_idx | output | 5 | First source register index, combinational |
| src2_idx | output | 5 | Second source register index, combinational |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_rd | output | 5 | Destination register index of the result |
| out_result | output | XLEN | Operation result |
| out_illegal | output | 1 | Function-field combination not supported |

## Verification
Directed patterns come first, each chosen to separate two readings of the spec. All-ones plus one and zero minus one show that the adder wraps. The most-negative value compared with zero must give opposite answers for the signed and unsigned compares. A negative operand shifted right by a logical and by an arithmetic shift exposes the fill bit. Shift amounts of 0 and XLEN-1, and values of B with high bits set, show whether the amount is masked correctly. Odd funct7 codes on every funct3 check the illegal path. A long random stream with idle gaps is then compared cycle by cycle against a behavioural model, which also covers latency, index routing and holding of outputs while idle.

// File: rtl/rr_alu_pkg.sv
// Package: shared operation encoding for the register-register ALU.
// Assumes funct7 codes follow the base integer OP-opcode layout.
package rr_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU,
        OP_XOR, OP_SRL, OP_SRA, OP_OR, OP_AND
    } alu_op_e;

    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

endpackage

// File: rtl/rr_alu_fields.sv
// Module: rr_alu_fields
// Splits a 32-bit register-register instruction word into register
// indices and function fields. Assumes the standard R-type layout.
module rr_alu_fields (
    input  logic [31:0] instr,
    output logic [4:0]  rd,
    output logic [4:0]  rs1,
    output logic [4:0]  rs2,
    output logic [2:0]  funct3,
    output logic [6:0]  funct7
);
    // Field slicing; pure wiring.
    assign rd     = instr[11:7];
    assign funct3 = instr[14:12];
    assign rs1    = instr[19:15];
    assign rs2    = instr[24:20];
    assign funct7 = instr[31:25];
endmodule

// File: rtl/rr_alu_decode.sv
// Module: rr_alu_decode
// Maps funct3/funct7 to an internal operation code and flags any
// combination outside the supported set. Assumes the caller has
// already established the OP opcode.
module rr_alu_decode
    import rr_alu_pkg::*;
(
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output alu_op_e    op,
    output logic       illegal
);
    logic f7_base, f7_alt;
    assign f7_base = (funct7 == F7_BASE);
    assign f7_alt  = (funct7 == F7_ALT);

    // Operation select; only 000 and 101 accept the alternate funct7.
    always_comb begin
        illegal = !f7_base;
        unique case (funct3)
            3'b000: begin op = f7_alt ? OP_SUB : OP_ADD; illegal = !(f7_base || f7_alt); end
            3'b001: op = OP_SLL;
            3'b010: op = OP_SLT;
            3'b011: op = OP_SLTU;
            3'b100: op = OP_XOR;
            3'b101: begin op = f7_alt ? OP_SRA : OP_SRL; illegal = !(f7_base || f7_alt); end
            3'b110: op = OP_OR;
            default: op = OP_AND;
        endcase
    end
endmodule

// File: rtl/rr_alu_exec.sv
// Module: rr_alu_exec
// Combinational datapath: one shared adder for add, subtract and
// both compares, and one right shifter used for all three shifts
// (left shift by bit reversal). Every operation uses the same logic
// depth regardless of data, so there is no early-out path.
// Assumes XLEN is a power of two (32 or 64).
module rr_alu_exec
    import rr_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] result
);
    localparam int SHW = $clog2(XLEN);

    // Shared adder: subtract for SUB and both compares.
    logic            use_sub;
    logic [XLEN:0]   sum;
    logic            lt_s, lt_u;
    assign use_sub = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
    assign sum     = {1'b0, a} + {1'b0, b ^ {XLEN{use_sub}}} + {{XLEN{1'b0}}, use_sub};
    assign lt_u    = !sum[XLEN];
    assign lt_s    = (a[XLEN-1] ^ b[XLEN-1]) ? a[XLEN-1] : sum[XLEN-1];

    // Shifter: reverse for left shift, fill with sign only for SRA.
    logic [SHW-1:0]    shamt;
    logic [XLEN-1:0]   a_rev, sh_src, shifted, sh_rev;
    logic [2*XLEN-1:0] wide;
    logic              fill, go_left;
    assign shamt   = b[SHW-1:0];
    assign go_left = (op == OP_SLL);
    assign fill    = (op == OP_SRA) && a[XLEN-1];

    for (genvar i = 0; i < XLEN; i++) begin : g_rev
        assign a_rev[i]  = a[XLEN-1-i];
        assign sh_rev[i] = shifted[XLEN-1-i];
    end

    assign sh_src  = go_left ? a_rev : a;
    assign wide    = {{XLEN{fill}}, sh_src} >> shamt;
    assign shifted = wide[XLEN-1:0];

    // Result select.
    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: result = sum[XLEN-1:0];
            OP_SLT:         result = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU:        result = {{(XLEN-1){1'b0}}, lt_u};
            OP_XOR:         result = a ^ b;
            OP_OR:          result = a | b;
            OP_AND:         result = a & b;
            OP_SLL:         result = sh_rev;
            OP_SRL, OP_SRA: result = shifted;
            default:        result = '0;
        endcase
    end
endmodule

// File: rtl/rr_int_alu.sv
// Module: rr_int_alu (top)
// Register-register integer ALU with one fixed register stage.
// Decodes the instruction's function fields, computes the result,
// and registers it with valid, destination index and illegal flag.
// Assumes the caller only strobes register-register instructions.
module rr_int_alu
    import rr_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic [4:0]      src1_idx,
    output logic [4:0]      src2_idx,
    output logic            out_valid,
    output logic [4:0]      out_rd,
    output logic [XLEN-1:0] out_result,
    output logic            out_illegal
);
    logic [4:0]      rd_idx;
    logic [2:0]      funct3;
    logic [6:0]      funct7;
    alu_op_e         op;
    logic            illegal;
    logic [XLEN-1:0] exec_res;

    rr_alu_fields u_fields (
        .instr  (instr),
        .rd     (rd_idx),
        .rs1    (src1_idx),
        .rs2    (src2_idx),
        .funct3 (funct3),
        .funct7 (funct7)
    );

    rr_alu_decode u_decode (
        .funct3  (funct3),
        .funct7  (funct7),
        .op      (op),
        .illegal (illegal)
    );

    rr_alu_exec #(.XLEN(XLEN)) u_exec (
        .a      (opnd_a),
        .b      (opnd_b),
        .op     (op),
        .result (exec_res)
    );

    // Valid flag: follows the strobe, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Payload: captured on an accepted strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            out_result  <= illegal ? '0 : exec_res;
            out_rd      <= rd_idx;
            out_illegal <= illegal;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_result == '0)); // R9
    AST_CMP_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_SLT || op == OP_SLTU)) |=> (out_result[XLEN-1:1] == '0)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_rd) && $stable(out_illegal))); // R11
endmodule

// File: tb/sim_rr_int_alu.sv
// Bench: drives at the falling edge, compares at the next falling
// edge against a behavioural model, every clock.
module sim_rr_int_alu;
    localparam int XLEN = 64;
    typedef logic [XLEN-1:0] word_t;

    logic clk = 0, rst_n = 0, in_valid = 0;
    logic [31:0] instr = '0;
    word_t opnd_a = '0, opnd_b = '0;
    logic [4:0] src1_idx, src2_idx, out_rd;
    logic out_valid, out_illegal;
    word_t out_result;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    rr_int_alu #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .src1_idx(src1_idx), .src2_idx(src2_idx),
        .out_valid(out_valid), .out_rd(out_rd), .out_result(out_result),
        .out_illegal(out_illegal)
    );

    // Expected state of the outputs after the next edge.
    logic   exp_valid = 0, have_data = 0, exp_ill = 0;
    logic [4:0] exp_rd = '0;
    word_t  exp_res = '0;
    string  exp_tag = "reset";

    task automatic chk(input bit ok, input string tag, input word_t act, input word_t exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs2,
            input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'b0110011};
    endfunction

    // Behavioural model; returns {illegal, result}.
    function automatic logic [XLEN:0] model(input logic [2:0] f3, input logic [6:0] f7,
            input word_t a, input word_t b);
        int sh;
        bit alt, base;
        sh   = int'(b % XLEN);
        alt  = (f7 == 7'b0100000);
        base = (f7 == 7'b0000000);
        if (!(base || (alt && (f3 == 3'b000 || f3 == 3'b101)))) return {1'b1, word_t'(0)};
        case (f3)
            3'b000: return {1'b0, alt ? word_t'(a - b) : word_t'(a + b)};
            3'b001: return {1'b0, word_t'(a << sh)};
            3'b010: return {1'b0, word_t'($signed(a) < $signed(b))};
            3'b011: return {1'b0, word_t'(a < b)};
            3'b100: return {1'b0, a ^ b};
            3'b101: return {1'b0, alt ? word_t'($signed(a) >>> sh) : word_t'(a >> sh)};
            3'b110: return {1'b0, a | b};
            default: return {1'b0, a & b};
        endcase
    endfunction

    // One clock: compare previous expectation, then drive new inputs.
    task automatic step(input bit v, input logic [31:0] ins, input word_t a, input word_t b,
            input string tag);
        logic [XLEN:0] m;
        @(negedge clk);
        chk(out_valid === exp_valid, {exp_tag, " valid (R8)"}, word_t'(out_valid), word_t'(exp_valid));
        if (have_data) begin
            chk(out_result === exp_res, {exp_tag, " result"}, out_result, exp_res);
            chk(out_rd === exp_rd, {exp_tag, " rd (R7)"}, word_t'(out_rd), word_t'(exp_rd));
            chk(out_illegal === exp_ill, {exp_tag, " illegal (R9)"}, word_t'(out_illegal), word_t'(exp_ill));
        end
        in_valid = v; instr = ins; opnd_a = a; opnd_b = b;
        #1;
        chk(src1_idx === ins[19:15], "R7 src1_idx", word_t'(src1_idx), word_t'(ins[19:15]));
        chk(src2_idx === ins[24:20], "R7 src2_idx", word_t'(src2_idx), word_t'(ins[24:20]));
        exp_valid = v;
        if (v) begin
            m = model(ins[14:12], ins[31:25], a, b);
            exp_res = m[XLEN-1:0]; exp_ill = m[XLEN]; exp_rd = ins[11:7];
            have_data = 1;
            exp_tag = tag;
        end else begin
            exp_tag = {tag, " idle hold (R11)"};
        end
    endtask

    localparam word_t ONES = '1;
    localparam word_t MINV = {1'b1, {(XLEN-1){1'b0}}};

    initial begin : main
        // R10: reset with strobe high keeps valid low.
        in_valid = 1; instr = mk(7'h00, 5'd2, 5'd1, 3'b000, 5'd3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R10 valid low in reset", word_t'(out_valid), 0);
        in_valid = 0;
        @(negedge clk);
        rst_n = 1;
        chk(out_valid === 1'b0, "R10 valid after reset", word_t'(out_valid), 0);

        step(1, mk(7'h00, 5'd2, 5'd1, 3'b000, 5'd4),  ONES, 1, "R1 add wrap");
        step(1, mk(7'h20, 5'd3, 5'd7, 3'b000, 5'd5),  0, 1, "R1 sub wrap");
        step(1, mk(7'h00, 5'd8, 5'd9, 3'b100, 5'd6),  64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_1111, "R2 xor");
        step(1, mk(7'h00, 5'd8, 5'd9, 3'b110, 5'd7),  64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_1111, "R2 or");
        step(1, mk(7'h00, 5'd8, 5'd9, 3'b111, 5'd8),  64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_1111, "R2 and");
        step(1, mk(7'h00, 5'd1, 5'd2, 3'b010, 5'd9),  MINV, 0, "R3 slt min<0");
        step(1, mk(7'h00, 5'd1, 5'd2, 3'b011, 5'd10), MINV, 0, "R4 sltu min<0");
        step(1, mk(7'h00, 5'd1, 5'd2, 3'b010, 5'd11), ONES, ONES, "R3 slt equal");
        step(1, mk(7'h00, 5'd1, 5'd2, 3'b011, 5'd12), 0, ONES, "R4 sltu 0<max");
        step(1, mk(7'h00, 5'd1, 5'd2, 3'b001, 5'd13), 64'h8000_0000_0000_0001, 0, "R5 sll by 0");
        step(1, mk(7'h00, 5'd1, 5'd2, 3'b001, 5'd14), 64'h3, XLEN-1, "R5 sll by max");
        step(1, mk(7'h00, 5'd1, 5'd2, 3'b101, 5'd15), ONES, ONES, "R5 srl masked high bits");
        step(1, mk(7'h00, 5'd1, 5'd2, 3'b101, 5'd16), MINV, 64'hFFFF_FF00_0000_0004, "R6 srl zero fill");
        step(1, mk(7'h20, 5'd1, 5'd2, 3'b101, 5'd17), MINV, 64'hFFFF_FF00_0000_0004, "R6 sra sign fill");
        step(1, mk(7'h20, 5'd1, 5'd2, 3'b101, 5'd18), 64'h4000_0000_0000_0000, XLEN-1, "R6 sra positive");
        step(0, mk(7'h00, 5'd30, 5'd29, 3'b000, 5'd31), 5, 6, "R11");
        step(1, mk(7'h20, 5'd1, 5'd2, 3'b111, 5'd19), ONES, ONES, "R9 and alt funct7");
        step(1, mk(7'h01, 5'd1, 5'd2, 3'b000, 5'd20), 5, 6, "R9 add odd funct7");
        step(1, mk(7'h20, 5'd1, 5'd2, 3'b001, 5'd21), 5, 1, "R9 sll alt funct7");

        // Random stream with idle gaps.
        for (int i = 0; i < 400; i++) begin
            logic [6:0] f7;
            int pick;
            pick = $urandom_range(0, 9);
            f7 = (pick < 4) ? 7'h00 : (pick < 8) ? 7'h20 : 7'($urandom);
            step(($urandom_range(0, 4) != 0),
                 mk(f7, 5'($urandom), 5'($urandom), 3'($urandom), 5'($urandom)),
                 {$urandom, $urandom}, {$urandom, $urandom}, "R1 random stream");
        end
        step(0, '0, 0, 0, "end");
        step(0, '0, 0, 0, "end");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (R8) actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule